// File: doc/BRIEF.md
# Three-Line Vertical Flicker Filter

This block removes interlace flicker from progressive graphics before the picture is split into TV fields. It takes a 16-bit 4:2:2 pixel stream, one pixel per accepted cycle, marked with line-start and frame-start flags. Each output line is a rounded 1/4, 1/2, 1/4 blend of three vertically adjacent input lines, taken down each pixel column. The blend band-limits sharp light/dark boundaries that would otherwise sit in only one field and flicker at the field rate. Two internal line stores, each up to 768 pixels deep, hold the previous two lines.

The luma byte and the chroma byte of each word are filtered as separate lanes. A word at a given column always carries the same chroma kind (U or V) on every line, so each column only mixes like samples. A filter enable picks between the blend and a plain pass-through. Both paths have the same one-line delay, so timing downstream does not change when the mode changes. At the top and bottom of a frame, the missing neighbour line is replaced by the edge line itself. The last line of a frame is produced while the first line of the next frame arrives.

Top module: `flicker_filter3`

## Requirements
- R1: With filtering on, an output pixel at column c equals, for each byte lane separately (luma in bits 7:0, chroma in bits 15:8), (above + 2*centre + below + 2) >> 2, where centre is column c of the line being output and above and below are column c of its neighbouring lines.
- R2: Output pixel (line n, column c) appears on outValid exactly one clock after input pixel (line n+1, column c) is accepted. outValid is never high unless an input was accepted on the previous clock.
- R3: For the first line of a frame, the line above is replaced by the line itself.
- R4: For the last line of a frame, the line below is replaced by the line itself. That line is produced while the first line of the next frame, marked by inSof with inSol, is accepted.
- R5: With filtEn low, the output is the centre line unchanged, with the same timing as R2. filtEn is sampled only on the first pixel of the input line that carries an output line, so a change in the middle of a line has no effect on that line.
- R6: After reset outValid is low, and no output is produced while the first input line after reset is accepted.
- R7: outSol is high with the column-0 output pixel of each line. outSof is high only with the column-0 pixel of the first line of a frame.
- R8: Lines of up to 768 pixels are filtered correctly, including column 767.
- R9: Cycles with inValid low produce no output and do not advance the column position.
- R10: No carry or borrow passes between byte lanes. Full-scale values (0xFF) in a lane stay within that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| filtEn | input | 1 | 1 selects the three-line blend, 0 selects pass-through |
| inValid | input | 1 | Input pixel valid |
| inSol | input | 1 | First pixel of a line (with inValid) |
| inSof | input | 1 | First line of a frame (with inSol) |
| inPix | input | 16 | Input pixel: chroma in 15:8, luma in 7:0 |
| outValid | output | 1 | Output pixel valid |
| outSol | output | 1 | Output pixel is column 0 of its line |
| outSof | output | 1 | Output line is the first line of its frame |
| outPix | output | 16 | Filtered or passed pixel, same byte layout as inPix |

## Verification
The assertions rely on the following input rules: inSof is raised only together with inSol, every line of a frame has the same length, and that length never exceeds the line-store depth. Under these rules the column index stays inside the stores, and the one-line-frame and pass-through checks can compare the output against the stored centre pixel. The stimulus follows the same rules. Every frame uses one fixed line length. Each test ends with a one-line frame of the same length, which pushes out the last line. Gaps with inValid low are inserted only between complete pixels.

// File: rtl/flick_pkg.sv
`timescale 1ns/1ps
package flick_pkg;
  localparam int LINE_MAX_DEF = 768;

  typedef struct packed {
    logic wr;          // accept input pixel, update stores
    logic emit;        // an output pixel is due for this column
    logic topFromMid;  // centre line opens its frame
    logic botFromMid;  // centre line closes its frame
    logic bypass;      // pass centre line through
    logic solOut;      // output pixel is column 0
    logic sofOut;      // output line opens its frame
  } flickStrb_t;
endpackage

// File: rtl/flick_ctrl.sv
`timescale 1ns/1ps
module flick_ctrl
  import flick_pkg::*;
#(
  parameter int LINE_MAX = LINE_MAX_DEF,
  localparam int COL_W = $clog2(LINE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             filtEn,
  input  logic             inValid,
  input  logic             inSol,
  input  logic             inSof,
  output flickStrb_t       strb,
  output logic [COL_W-1:0] colIdx
);
  logic [COL_W-1:0] colReg;
  logic started, haveMid, curFirst, prevFirst, bypassReg;
  logic accept;

  assign accept = inValid & (inSol | started);
  assign colIdx = inSol ? '0 : colReg;

  always_comb begin
    strb.wr         = accept;
    strb.emit       = accept & (inSol ? started : haveMid);
    strb.topFromMid = inSol ? curFirst : prevFirst;
    strb.botFromMid = inSol ? inSof : curFirst;
    strb.bypass     = inSol ? ~filtEn : bypassReg;
    strb.solOut     = inSol;
    strb.sofOut     = inSol & curFirst;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colReg    <= '0;
      started   <= 1'b0;
      haveMid   <= 1'b0;
      curFirst  <= 1'b0;
      prevFirst <= 1'b0;
      bypassReg <= 1'b0;
    end else if (accept) begin
      colReg <= colIdx + 1'b1;
      if (inSol) begin
        started   <= 1'b1;
        haveMid   <= started;
        prevFirst <= curFirst;
        curFirst  <= inSof;
        bypassReg <= ~filtEn;
      end
    end
  end

  // R8
  col_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wr |-> (int'(colIdx) < LINE_MAX));

  // R6
  first_line_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSol && !started) |-> !strb.emit);
endmodule

// File: rtl/flick_dp.sv
`timescale 1ns/1ps
module flick_dp
  import flick_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int LANE_W   = 8,
  parameter int LINE_MAX = LINE_MAX_DEF,
  localparam int COL_W = $clog2(LINE_MAX + 1),
  localparam int LANES = PIX_W / LANE_W,
  localparam int SUM_W = LANE_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  flickStrb_t       strb,
  input  logic [COL_W-1:0] colIdx,
  input  logic [PIX_W-1:0] inPix,
  output logic             outValid,
  output logic             outSol,
  output logic             outSof,
  output logic [PIX_W-1:0] outPix
);
  logic [PIX_W-1:0] midMem [LINE_MAX];
  logic [PIX_W-1:0] topMem [LINE_MAX];
  logic [PIX_W-1:0] midPix, topRaw, topSel, botSel, filtPix;

  assign midPix = midMem[colIdx];
  assign topRaw = topMem[colIdx];
  assign topSel = strb.topFromMid ? midPix : topRaw;
  assign botSel = strb.botFromMid ? midPix : inPix;

  // lines move down one store per accepted pixel of the same column
  always_ff @(posedge clk) begin
    if (strb.wr) begin
      midMem[colIdx] <= inPix;
      topMem[colIdx] <= midPix;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SUM_W-1:0] acc;
    always_comb acc = {2'b00, topSel[l*LANE_W +: LANE_W]}
                    + {1'b0, midPix[l*LANE_W +: LANE_W], 1'b0}
                    + {2'b00, botSel[l*LANE_W +: LANE_W]}
                    + SUM_W'(2);
    assign filtPix[l*LANE_W +: LANE_W] = LANE_W'(acc >> 2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSol   <= 1'b0;
      outSof   <= 1'b0;
      outPix   <= '0;
    end else begin
      outValid <= strb.wr & strb.emit;
      outSol   <= strb.wr & strb.emit & strb.solOut;
      outSof   <= strb.wr & strb.emit & strb.sofOut;
      if (strb.wr && strb.emit)
        outPix <= strb.bypass ? midPix : filtPix;
    end
  end

  // R5
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.emit && strb.bypass) |=> (outPix == $past(midPix)));

  // R3
  flat_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wr && strb.emit && strb.topFromMid && strb.botFromMid)
      |=> (outPix == $past(midPix)));
endmodule

// File: rtl/flicker_filter3.sv
`timescale 1ns/1ps
module flicker_filter3
  import flick_pkg::*;
#(
  parameter int PIX_W    = 16,
  parameter int LANE_W   = 8,
  parameter int LINE_MAX = LINE_MAX_DEF,
  localparam int COL_W = $clog2(LINE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             filtEn,
  input  logic             inValid,
  input  logic             inSol,
  input  logic             inSof,
  input  logic [PIX_W-1:0] inPix,
  output logic             outValid,
  output logic             outSol,
  output logic             outSof,
  output logic [PIX_W-1:0] outPix
);
  flickStrb_t       strb;
  logic [COL_W-1:0] colIdx;

  flick_ctrl #(.LINE_MAX(LINE_MAX)) i_ctrl (
    .clk(clk), .rstN(rstN), .filtEn(filtEn), .inValid(inValid),
    .inSol(inSol), .inSof(inSof), .strb(strb), .colIdx(colIdx)
  );

  flick_dp #(.PIX_W(PIX_W), .LANE_W(LANE_W), .LINE_MAX(LINE_MAX)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .colIdx(colIdx), .inPix(inPix),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outPix(outPix)
  );

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid));

  // R7
  sof_marker_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outSol && outValid));
endmodule

// File: tb/test_flicker_filter3.sv
`timescale 1ns/1ps
module test_flicker_filter3;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic filtEn = 1'b1;
  logic inValid = 1'b0, inSol = 1'b0, inSof = 1'b0;
  logic [15:0] inPix = '0;
  logic outValid, outSol, outSof;
  logic [15:0] outPix;

  always #4 clk = ~clk;

  flicker_filter3 i_flicker_filter3 (
    .clk(clk), .rstN(rstN), .filtEn(filtEn), .inValid(inValid),
    .inSol(inSol), .inSof(inSof), .inPix(inPix),
    .outValid(outValid), .outSol(outSol), .outSof(outSof), .outPix(outPix)
  );

  int nTests = 0, nFail = 0;
  logic [15:0] frm [0:3][0:767];
  logic [15:0] capPix [0:3071];
  logic capSol [0:3071];
  logic capSof [0:3071];
  int capN = 0, latErr = 0;
  logic sampledValid = 1'b0;
  bit enArr [0:4];
  int seed = 32'h1234_5678;

  // {above, centre, below, expected centre-line output}
  localparam logic [15:0] VEC [7][4] = '{
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000},
    '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    '{16'h1020, 16'h3040, 16'h5060, 16'h3040},
    '{16'h00FF, 16'h0000, 16'h00FF, 16'h0080},
    '{16'h0001, 16'h0000, 16'h0000, 16'h0000},
    '{16'h0002, 16'h0000, 16'h0000, 16'h0001},
    '{16'hFF00, 16'h00FF, 16'hFF00, 16'h8080}
  };

  always @(posedge clk) sampledValid <= inValid;

  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (capN < 3072) begin
        capPix[capN] = outPix;
        capSol[capN] = outSol;
        capSof[capN] = outSof;
      end
      capN++;
      if (!sampledValid) latErr++;
    end
  end

  function automatic logic [15:0] ref3(input logic [15:0] a, b, c);
    logic [15:0] r;
    for (int l = 0; l < 2; l++)
      r[l*8 +: 8] = 8'((int'(a[l*8 +: 8]) + 2*int'(b[l*8 +: 8]) + int'(c[l*8 +: 8]) + 2) / 4);
    return r;
  endfunction

  function automatic logic [15:0] nextRand();
    seed = seed * 1103515245 + 12345;
    return 16'(seed >>> 8);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic doReset();
    cyc();
    rstN = 1'b0; inValid = 1'b0; inSol = 1'b0; inSof = 1'b0;
    repeat (3) cyc();
    chk(outValid == 1'b0, "R6", "outValid in reset", 16'(outValid), 16'h0);
    rstN = 1'b1;
    capN = 0;
    latErr = 0;
  endtask

  task automatic runFrame(input int nL, input int len, input int gap, input bit glitch);
    for (int k = 0; k <= nL; k++) begin
      if (k == 1)
        chk(capN == 0, "R6", "output during first line", 16'(capN), 16'h0);
      for (int c = 0; c < len; c++) begin
        for (int g = 0; g < gap; g++) begin
          cyc();
          inValid = 1'b0; inSol = 1'b0; inSof = 1'b0;
        end
        cyc();
        inValid = 1'b1;
        inSol = (c == 0);
        inSof = (c == 0) && (k == 0 || k == nL);
        inPix = (k < nL) ? frm[k][c] : 16'h0000;
        if (c == 0) filtEn = enArr[k];
        else if (glitch && c == 1) filtEn = ~enArr[k];
      end
    end
    cyc();
    inValid = 1'b0; inSol = 1'b0; inSof = 1'b0;
    repeat (3) cyc();
  endtask

  task automatic checkFrame(input int nL, input int len);
    bit okMark = 1'b1;
    chk(capN == nL*len, "R2 R9", "output pixel count", 16'(capN), 16'(nL*len));
    chk(latErr == 0, "R2", "output without prior input", 16'(latErr), 16'h0);
    for (int k = 0; k < nL; k++) begin
      bit ok = 1'b1;
      logic [15:0] a = '0, e = '0;
      string tag;
      for (int c = 0; c < len; c++) begin
        logic [15:0] up, dn, ex;
        int idx = k*len + c;
        up = (k == 0) ? frm[k][c] : frm[k-1][c];
        dn = (k == nL-1) ? frm[k][c] : frm[k+1][c];
        ex = enArr[k+1] ? ref3(up, frm[k][c], dn) : frm[k][c];
        if (idx < 3072) begin
          if (ok && capPix[idx] !== ex) begin ok = 1'b0; a = capPix[idx]; e = ex; end
          if (capSol[idx] !== (c == 0) || capSof[idx] !== (c == 0 && k == 0)) okMark = 1'b0;
        end
      end
      if (!enArr[k+1]) tag = "R5";
      else if (k == 0) tag = "R3";
      else if (k == nL-1) tag = "R4";
      else tag = "R1";
      if (len == 768) tag = {tag, " R8"};
      chk(ok, tag, $sformatf("line %0d pixels", k), a, e);
    end
    chk(okMark, "R7", "line and frame markers", 16'(okMark), 16'h1);
  endtask

  task automatic fillRand(input int nL, input int len);
    for (int k = 0; k < nL; k++)
      for (int c = 0; c < len; c++) frm[k][c] = nextRand();
  endtask

  initial begin
    #(8 * 150000);
    nFail++;
    nTests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    // table walk: three flat lines, check the centre line against the table
    foreach (VEC[v]) begin
      for (int k = 0; k < 5; k++) enArr[k] = 1'b1;
      for (int c = 0; c < 4; c++) begin
        frm[0][c] = VEC[v][0]; frm[1][c] = VEC[v][1]; frm[2][c] = VEC[v][2];
      end
      doReset();
      runFrame(3, 4, 0, 1'b0);
      chk(capPix[5] === VEC[v][3], "R1 R10", $sformatf("vector %0d centre", v),
          capPix[5], VEC[v][3]);
      checkFrame(3, 4);
    end

    // one-line frame: both edges fall back to the line itself (R3, R4)
    for (int k = 0; k < 5; k++) enArr[k] = 1'b1;
    for (int c = 0; c < 6; c++) frm[0][c] = 16'h5A3C + 16'(c);
    doReset();
    runFrame(1, 6, 0, 1'b0);
    checkFrame(1, 6);

    // random four-line frame with idle gaps (R9, R1)
    fillRand(4, 16);
    doReset();
    runFrame(4, 16, 1, 1'b0);
    checkFrame(4, 16);

    // pass-through with full-scale contrast lines (R5)
    for (int k = 0; k < 5; k++) enArr[k] = 1'b0;
    for (int k = 0; k < 4; k++)
      for (int c = 0; c < 8; c++) frm[k][c] = (k % 2) ? 16'hFFFF : 16'h0000;
    doReset();
    runFrame(4, 8, 0, 1'b0);
    checkFrame(4, 8);

    // mixed enable per line, toggled mid-line (R5)
    enArr[0] = 1'b1; enArr[1] = 1'b0; enArr[2] = 1'b1; enArr[3] = 1'b0; enArr[4] = 1'b1;
    fillRand(4, 10);
    doReset();
    runFrame(4, 10, 0, 1'b1);
    checkFrame(4, 10);

    // full-length lines (R8)
    for (int k = 0; k < 5; k++) enArr[k] = 1'b1;
    fillRand(3, 768);
    doReset();
    runFrame(3, 768, 0, 1'b0);
    checkFrame(3, 768);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule